// File: doc/BRIEF.md
# Instruction Sampling Tag Unit

This block picks one fetched instruction at a time for profiling and follows it through the pipeline. A down-counter is stepped by the fetch strobe. When the counter runs out, the block arms itself, and the next fetched instruction becomes the tagged one. The block records that instruction's PC and its global branch history at fetch. From then on, each pipeline event strobe that carries a slot ID is compared with the slot ID of the tagged instruction.

While the instruction is in flight, the block records its data address, its cache miss flags, its branch outcome and the number of cycles between each pair of stages. It raises the interrupt only after the instruction has retired or aborted. The handler then reads the PC that was recorded for the instruction itself, not the restart PC, so skew and smear do not affect attribution.

Each reload of the interval adds a random amount to a base period. The random amount is taken from a 16-bit LFSR, so the sampled instructions do not fall into step with loop periods. Only one sample can be in progress at a time. Software frees the unit for the next sample by pulsing `sw_clear`.

Top module: `insn_sample_tagger`

## Requirements
- R1: After reset, `irq` is low and every capture output and latency field is zero. The interval counter starts at zero, so the first fetch after reset runs the counter out and the second fetch is tagged.
- R2: When a fetch finds the counter at zero, the counter reloads to `cfg_base + (L & M)`, truncated to CNT_W bits. L is the current LFSR value and M is a mask of `cfg_rand_bits` ones (16 ones when the count is 16 or more). The LFSR starts at 16'hACE1 and steps once per reload: shift right by one, then XOR with 16'hB400 when the bit shifted out was 1. Any other fetch decrements the counter.
- R3: The first fetch after the counter runs out, taken while the unit is idle, is tagged. Its `fe_pc`, `fe_slot` and `fe_hist` are captured at that fetch.
- R4: Only one instruction is tagged at a time. From arming until `sw_clear`, a run-out of the counter is ignored, but the counter still reloads. Later fetches do not change the captures.
- R5: Event strobes take effect only when their slot equals the tagged slot. A tagged execute event captures `exe_addr`, otherwise `cap_addr` is 0. A tagged I-cache or D-cache miss event sets its flag. A tagged branch event sets `cap_branch` and captures `br_taken` and `br_mispred`. A tagged completion event captures `done_retired`.
- R6: `cap_lat` holds four LAT_W-bit fields, field k at bits [k*LAT_W +: LAT_W]. The fields are fetch-to-map (k=0), map-to-issue (k=1), issue-to-execute (k=2) and execute-to-completion (k=3). Each field equals the number of clock cycles between the two events, and a stage that was never entered reads 0.
- R7: A latency field stops at its all-ones value and does not wrap.
- R8: `irq` rises in the cycle after the tagged completion event and not before. It stays high until `sw_clear` returns the unit to idle.
- R9: A completion with `done_retired`=0 (abort) clears `cap_retired`, freezes any latency field still running and still raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | CNT_W | Base sampling period in fetches |
| cfg_rand_bits | input | RB_W | Number of LFSR low bits added at reload |
| fe_valid | input | 1 | Fetch strobe |
| fe_pc | input | PC_W | PC of the fetched instruction |
| fe_slot | input | SLOT_W | Slot ID given to the fetched instruction |
| fe_hist | input | HIST_W | Global branch history at fetch |
| map_vld | input | 1 | Map stage event |
| map_slot | input | SLOT_W | Slot of the map event |
| iss_vld | input | 1 | Issue stage event |
| iss_slot | input | SLOT_W | Slot of the issue event |
| exe_vld | input | 1 | Execute stage event |
| exe_slot | input | SLOT_W | Slot of the execute event |
| exe_addr | input | ADDR_W | Effective data address |
| icm_vld | input | 1 | I-cache miss event |
| icm_slot | input | SLOT_W | Slot of the I-cache miss |
| dcm_vld | input | 1 | D-cache miss event |
| dcm_slot | input | SLOT_W | Slot of the D-cache miss |
| br_vld | input | 1 | Branch resolution event |
| br_slot | input | SLOT_W | Slot of the branch event |
| br_taken | input | 1 | Branch direction |
| br_mispred | input | 1 | Branch was mispredicted |
| done_vld | input | 1 | Completion event (retire or abort) |
| done_slot | input | SLOT_W | Slot of the completion event |
| done_retired | input | 1 | 1 = retired, 0 = aborted |
| sw_clear | input | 1 | Software release of a pending sample |
| cap_pc | output | PC_W | Tagged PC |
| cap_addr | output | ADDR_W | Tagged data address |
| cap_hist | output | HIST_W | Tagged branch history |
| cap_retired | output | 1 | Tagged instruction retired |
| cap_icmiss | output | 1 | I-cache miss seen |
| cap_dcmiss | output | 1 | D-cache miss seen |
| cap_branch | output | 1 | Branch event seen |
| cap_taken | output | 1 | Branch direction |
| cap_mispred | output | 1 | Branch mispredicted |
| cap_lat | output | 4*LAT_W | Stage latency fields |
| irq | output | 1 | Sample ready interrupt |

## Verification
The bench drives the same event kinds on a slot other than the tagged one before any tagged event. A design that matched on the strobe alone would stop `fetch-to-map` early, set miss or branch flags, or raise `irq` at once.

Aborts are placed at every stage. A wrong freeze would leave later latency fields counting or give an early field the wrong value, and `cap_retired` would read 1.

A fetch-to-map gap longer than the field can hold shows whether the counter wraps.

Fetches while a sample is pending, under randomized base periods and random widths, show whether a run-out of the counter is ignored but still reloads. A design that skipped the reload, or stepped the LFSR at the wrong time, would tag a different PC on every later sample.

// File: rtl/samp_pkg.sv
package samp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_TRACK, ST_DONE} tag_st_e;

  localparam int NUM_LAT = 4;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

  // Galois step, right-shifting
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? LFSR_TAPS : 16'h0000);
  endfunction

  // n low ones, capped at 16
  function automatic logic [15:0] rand_mask(input int unsigned n);
    logic [31:0] m;
    if (n >= 16) return 16'hFFFF;
    m = (32'd1 << n) - 32'd1;
    return m[15:0];
  endfunction

  function automatic logic slot_hit(input logic vld, input logic [7:0] a, input logic [7:0] b);
    return vld && (a == b);
  endfunction
endpackage

// File: rtl/samp_interval_gen.sv
module samp_interval_gen #(
  parameter int CNT_W = 20,
  parameter int RB_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch,
  input  logic [CNT_W-1:0] base,
  input  logic [RB_W-1:0]  rand_bits,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt;
  logic [15:0]      lfsr;
  logic [CNT_W-1:0] rnd_ext;
  logic [CNT_W-1:0] reload_val;

  assign rnd_ext    = CNT_W'(lfsr & samp_pkg::rand_mask(int'(rand_bits)));
  assign reload_val = base + rnd_ext;
  assign ovf        = fetch && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lfsr <= samp_pkg::LFSR_SEED;
    end else if (fetch) begin
      if (cnt == '0) begin
        cnt  <= reload_val;
        lfsr <= samp_pkg::lfsr_step(lfsr);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> ($stable(cnt) && $stable(lfsr)));
endmodule

// File: rtl/samp_lat_ctr.sv
module samp_lat_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start,
  input  logic         stop,
  output logic [W-1:0] lat
);
  localparam logic [W-1:0] LAT_MAX = {W{1'b1}};
  logic run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      lat <= '0;
    end else if (clr) begin
      run <= start;
      lat <= '0;
    end else begin
      if (run && lat != LAT_MAX) lat <= lat + 1'b1;
      if (stop)       run <= 1'b0;
      else if (start) run <= 1'b1;
    end
  end

  // R7
  lat_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == LAT_MAX && !clr) |=> lat == LAT_MAX);
  // R6
  lat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(lat));
endmodule

// File: rtl/insn_sample_tagger.sv
module insn_sample_tagger #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 3,
  parameter int HIST_W = 8,
  parameter int CNT_W  = 20,
  parameter int LAT_W  = 6,
  parameter int RB_W   = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [CNT_W-1:0]                     cfg_base,
  input  logic [RB_W-1:0]                      cfg_rand_bits,
  input  logic                                 fe_valid,
  input  logic [PC_W-1:0]                      fe_pc,
  input  logic [SLOT_W-1:0]                    fe_slot,
  input  logic [HIST_W-1:0]                    fe_hist,
  input  logic                                 map_vld,
  input  logic [SLOT_W-1:0]                    map_slot,
  input  logic                                 iss_vld,
  input  logic [SLOT_W-1:0]                    iss_slot,
  input  logic                                 exe_vld,
  input  logic [SLOT_W-1:0]                    exe_slot,
  input  logic [ADDR_W-1:0]                    exe_addr,
  input  logic                                 icm_vld,
  input  logic [SLOT_W-1:0]                    icm_slot,
  input  logic                                 dcm_vld,
  input  logic [SLOT_W-1:0]                    dcm_slot,
  input  logic                                 br_vld,
  input  logic [SLOT_W-1:0]                    br_slot,
  input  logic                                 br_taken,
  input  logic                                 br_mispred,
  input  logic                                 done_vld,
  input  logic [SLOT_W-1:0]                    done_slot,
  input  logic                                 done_retired,
  input  logic                                 sw_clear,
  output logic [PC_W-1:0]                      cap_pc,
  output logic [ADDR_W-1:0]                    cap_addr,
  output logic [HIST_W-1:0]                    cap_hist,
  output logic                                 cap_retired,
  output logic                                 cap_icmiss,
  output logic                                 cap_dcmiss,
  output logic                                 cap_branch,
  output logic                                 cap_taken,
  output logic                                 cap_mispred,
  output logic [samp_pkg::NUM_LAT*LAT_W-1:0]   cap_lat,
  output logic                                 irq
);
  import samp_pkg::*;

  tag_st_e           st;
  logic [SLOT_W-1:0] tag_slot;
  logic              ovf, arm_evt, tag_evt, tracking;
  logic              hit_map, hit_iss, hit_exe, hit_icm, hit_dcm, hit_br, done_evt;
  logic [NUM_LAT-1:0] lat_start, lat_stop;

  samp_interval_gen #(.CNT_W(CNT_W), .RB_W(RB_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .fetch(fe_valid),
    .base(cfg_base), .rand_bits(cfg_rand_bits), .ovf(ovf)
  );

  assign tracking = (st == ST_TRACK);
  assign arm_evt  = ovf && (st == ST_IDLE);
  assign tag_evt  = fe_valid && (st == ST_ARMED);
  assign hit_map  = tracking && slot_hit(map_vld,  8'(map_slot),  8'(tag_slot));
  assign hit_iss  = tracking && slot_hit(iss_vld,  8'(iss_slot),  8'(tag_slot));
  assign hit_exe  = tracking && slot_hit(exe_vld,  8'(exe_slot),  8'(tag_slot));
  assign hit_icm  = tracking && slot_hit(icm_vld,  8'(icm_slot),  8'(tag_slot));
  assign hit_dcm  = tracking && slot_hit(dcm_vld,  8'(dcm_slot),  8'(tag_slot));
  assign hit_br   = tracking && slot_hit(br_vld,   8'(br_slot),   8'(tag_slot));
  assign done_evt = tracking && slot_hit(done_vld, 8'(done_slot), 8'(tag_slot));

  assign lat_start = {hit_exe, hit_iss, hit_map, tag_evt};
  assign lat_stop  = {done_evt, hit_exe | done_evt, hit_iss | done_evt, hit_map | done_evt};

  for (genvar k = 0; k < NUM_LAT; k++) begin : g_lat
    samp_lat_ctr #(.W(LAT_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .clr(tag_evt),
      .start(lat_start[k]), .stop(lat_stop[k]),
      .lat(cap_lat[k*LAT_W +: LAT_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      tag_slot    <= '0;
      cap_pc      <= '0;
      cap_addr    <= '0;
      cap_hist    <= '0;
      cap_retired <= 1'b0;
      cap_icmiss  <= 1'b0;
      cap_dcmiss  <= 1'b0;
      cap_branch  <= 1'b0;
      cap_taken   <= 1'b0;
      cap_mispred <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:  if (arm_evt)  st <= ST_ARMED;
        ST_ARMED: if (tag_evt)  st <= ST_TRACK;
        ST_TRACK: if (done_evt) st <= ST_DONE;
        ST_DONE:  if (sw_clear) st <= ST_IDLE;
        default:                st <= ST_IDLE;
      endcase
      if (tag_evt) begin
        tag_slot    <= fe_slot;
        cap_pc      <= fe_pc;
        cap_hist    <= fe_hist;
        cap_addr    <= '0;
        cap_retired <= 1'b0;
        cap_icmiss  <= 1'b0;
        cap_dcmiss  <= 1'b0;
        cap_branch  <= 1'b0;
        cap_taken   <= 1'b0;
        cap_mispred <= 1'b0;
      end
      if (hit_exe) cap_addr   <= exe_addr;
      if (hit_icm) cap_icmiss <= 1'b1;
      if (hit_dcm) cap_dcmiss <= 1'b1;
      if (hit_br) begin
        cap_branch  <= 1'b1;
        cap_taken   <= br_taken;
        cap_mispred <= br_mispred;
      end
      if (done_evt) cap_retired <= done_retired;
    end
  end

  assign irq = (st == ST_DONE);

  // R3
  tag_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_evt |=> (cap_pc == $past(fe_pc) && cap_hist == $past(fe_hist)));
  // R4
  one_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && fe_valid) |=> $stable(cap_pc));
  // R8
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_evt));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sw_clear) |=> irq);
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !done_retired) |=> (irq && !cap_retired));
endmodule

// File: tb/insn_sample_tagger_tb_top.sv
module insn_sample_tagger_tb_top;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [19:0] cfg_base = '0;
  logic [4:0]  cfg_rand_bits = '0;
  logic fe_valid = 0; logic [31:0] fe_pc = '0; logic [2:0] fe_slot = '0; logic [7:0] fe_hist = '0;
  logic map_vld = 0, iss_vld = 0, exe_vld = 0, icm_vld = 0, dcm_vld = 0, br_vld = 0, done_vld = 0;
  logic [2:0] map_slot = '0, iss_slot = '0, exe_slot = '0, icm_slot = '0, dcm_slot = '0, br_slot = '0, done_slot = '0;
  logic [31:0] exe_addr = '0;
  logic br_taken = 0, br_mispred = 0, done_retired = 0, sw_clear = 0;
  logic [31:0] cap_pc, cap_addr;
  logic [7:0]  cap_hist;
  logic cap_retired, cap_icmiss, cap_dcmiss, cap_branch, cap_taken, cap_mispred, irq;
  logic [4*LW-1:0] cap_lat;

  insn_sample_tagger dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_rand_bits(cfg_rand_bits),
    .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_slot(fe_slot), .fe_hist(fe_hist),
    .map_vld(map_vld), .map_slot(map_slot), .iss_vld(iss_vld), .iss_slot(iss_slot),
    .exe_vld(exe_vld), .exe_slot(exe_slot), .exe_addr(exe_addr),
    .icm_vld(icm_vld), .icm_slot(icm_slot), .dcm_vld(dcm_vld), .dcm_slot(dcm_slot),
    .br_vld(br_vld), .br_slot(br_slot), .br_taken(br_taken), .br_mispred(br_mispred),
    .done_vld(done_vld), .done_slot(done_slot), .done_retired(done_retired),
    .sw_clear(sw_clear), .cap_pc(cap_pc), .cap_addr(cap_addr), .cap_hist(cap_hist),
    .cap_retired(cap_retired), .cap_icmiss(cap_icmiss), .cap_dcmiss(cap_dcmiss),
    .cap_branch(cap_branch), .cap_taken(cap_taken), .cap_mispred(cap_mispred),
    .cap_lat(cap_lat), .irq(irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench reference state
  int m_cnt = 0;
  bit [15:0] m_lfsr = 16'hACE1;
  int m_st = 0;               // 0 idle, 1 armed, 2 busy
  int cur_base = 0, cur_rb = 0;
  bit [31:0] exp_pc, next_pc = 32'h1000;
  bit [7:0]  exp_hist;
  bit [2:0]  exp_slot;

  function automatic bit [15:0] b_lfsr(bit [15:0] s);
    bit out_bit = s[0];
    s = s >> 1;
    if (out_bit) s = s ^ 16'hB400;
    return s;
  endfunction

  function automatic int b_reload(int base, bit [15:0] l, int n);
    int m = (n >= 16) ? 32'hFFFF : ((1 << n) - 1);
    return (base + (int'(l) & m)) & 32'hFFFFF;
  endfunction

  function automatic int b_sat(int d);
    return (d > 63) ? 63 : d;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_ev();
    map_vld = 0; iss_vld = 0; exe_vld = 0; icm_vld = 0; dcm_vld = 0; br_vld = 0; done_vld = 0;
    br_taken = 0; br_mispred = 0; done_retired = 0;
  endtask

  task automatic fetch(bit [31:0] pc, bit [2:0] sl, bit [7:0] h);
    int prior = m_st;
    fe_valid = 1; fe_pc = pc; fe_slot = sl; fe_hist = h;
    if (prior == 1) begin exp_pc = pc; exp_hist = h; exp_slot = sl; m_st = 2; end
    if (m_cnt == 0) begin
      if (prior == 0) m_st = 1;
      m_cnt = b_reload(cur_base, m_lfsr, cur_rb);
      m_lfsr = b_lfsr(m_lfsr);
    end else m_cnt--;
    tick();
    fe_valid = 0;
  endtask

  // a: stage at which abort happens (0..3), 4 = retire after execute
  task automatic run_sample(int base, int rb, int d0, int d1, int d2, int d3, int a,
                            bit fi, bit fd, bit fb, bit ft, bit fm, bit distract, bit busy_fetch);
    int d[4];
    int exp_lat[4];
    bit [31:0] exp_addr = 0;
    bit [2:0] wrong;
    int guard = 0;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    for (int k = 0; k < 4; k++) exp_lat[k] = 0;
    cfg_base = 20'(base); cfg_rand_bits = 5'(rb); cur_base = base; cur_rb = rb;
    while (m_st != 2 && guard < 5000) begin
      fetch(next_pc, 3'($urandom % 8), 8'($urandom % 256));
      next_pc += 4; guard++;
    end
    chk("R2", "tag reached", 64'(m_st == 2), 64'd1);
    wrong = exp_slot ^ 3'd1;
    for (int j = 0; j < 4; j++) begin
      bit last = (j == a) || (j == 3);
      for (int g = 1; g < d[j]; g++) begin
        if (j == 0 && g == 1 && distract) begin
          map_vld = 1; map_slot = wrong; iss_vld = 1; iss_slot = wrong;
          exe_vld = 1; exe_slot = wrong; exe_addr = 32'hDEAD0000;
          icm_vld = 1; icm_slot = wrong; dcm_vld = 1; dcm_slot = wrong;
          br_vld = 1; br_slot = wrong; br_taken = 1; br_mispred = 1;
          done_vld = 1; done_slot = wrong; done_retired = 1;
        end
        tick(); clr_ev();
      end
      if (last) begin
        chk("R8", "irq before completion", 64'(irq), 64'd0);
        done_vld = 1; done_slot = exp_slot; done_retired = (a == 4);
      end else if (j == 0) begin
        map_vld = 1; map_slot = exp_slot;
      end else if (j == 1) begin
        iss_vld = 1; iss_slot = exp_slot;
      end else begin
        exe_vld = 1; exe_slot = exp_slot; exe_addr = $urandom; exp_addr = exe_addr;
      end
      if (j == 0) begin
        icm_vld = fi; icm_slot = exp_slot; dcm_vld = fd; dcm_slot = exp_slot;
        br_vld = fb; br_slot = exp_slot; br_taken = ft; br_mispred = fm;
      end
      exp_lat[j] = b_sat(d[j]);
      tick(); clr_ev();
      if (last) break;
    end
    chk("R8", "irq after completion", 64'(irq), 64'd1);
    chk("R2 R3", "cap_pc", 64'(cap_pc), 64'(exp_pc));
    chk("R3", "cap_hist", 64'(cap_hist), 64'(exp_hist));
    chk((a == 4) ? "R5" : "R9", "cap_retired", 64'(cap_retired), 64'(a == 4));
    chk("R5", "cap_addr", 64'(cap_addr), 64'(exp_addr));
    chk("R5", "cap_icmiss", 64'(cap_icmiss), 64'(fi));
    chk("R5", "cap_dcmiss", 64'(cap_dcmiss), 64'(fd));
    chk("R5", "cap_branch", 64'(cap_branch), 64'(fb));
    chk("R5", "cap_taken", 64'(cap_taken), 64'(fb & ft));
    chk("R5", "cap_mispred", 64'(cap_mispred), 64'(fb & fm));
    for (int k = 0; k < 4; k++)
      chk((a < 4) ? "R6 R9" : ((d[k] > 63) ? "R7" : "R6"), $sformatf("lat%0d", k),
          64'(cap_lat[k*LW +: LW]), 64'(exp_lat[k]));
    if (busy_fetch) begin
      for (int i = 0; i < 6; i++) begin
        fetch(next_pc, 3'(i), 8'(i)); next_pc += 4;
      end
      chk("R4", "cap_pc held while pending", 64'(cap_pc), 64'(exp_pc));
      chk("R4", "irq held while pending", 64'(irq), 64'd1);
    end
    sw_clear = 1; tick(); sw_clear = 0; m_st = 0;
    chk("R8", "irq after sw_clear", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1", "irq", 64'(irq), 64'd0);
    chk("R1", "cap_lat", 64'(cap_lat), 64'd0);
    chk("R1", "cap_pc", 64'(cap_pc), 64'd0);
    chk("R1", "cap_retired", 64'(cap_retired), 64'd0);
    // R1: second fetch after reset is tagged
    run_sample(3, 0, 2, 3, 1, 4, 4, 1, 0, 1, 1, 0, 1, 0);
    chk("R1", "second fetch tagged", 64'(cap_pc), 64'h1004);
    // R7 saturation
    run_sample(2, 2, 80, 3, 2, 5, 4, 0, 1, 0, 0, 0, 0, 0);
    // R9 abort at each stage, R4 fetches while pending
    run_sample(1, 3, 4, 2, 2, 2, 0, 1, 1, 1, 0, 1, 1, 1);
    run_sample(0, 1, 2, 5, 2, 2, 1, 0, 0, 1, 1, 1, 1, 0);
    run_sample(4, 4, 3, 2, 6, 2, 2, 1, 0, 0, 0, 0, 0, 1);
    run_sample(2, 0, 1, 1, 1, 3, 3, 0, 1, 1, 1, 0, 0, 0);
    // randomized mix
    for (int s = 0; s < 40; s++) begin
      int av = $urandom % 8;
      run_sample($urandom % 7, $urandom % 5, 1 + $urandom % 7, 1 + $urandom % 7,
                 1 + $urandom % 7, 1 + $urandom % 7, (av > 4) ? 4 : av,
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule